// File: doc/BRIEF.md
# Memory Controller Performance Counter Unit

This block counts DRAM controller activity for profiling. The controller drives a vector of single-cycle event strobes. The block provides four counters, and software reaches each one through a small register port. Every counter has a control word that holds its enable, its clear bit, a sticky overflow flag and an 8-bit event-select code. The counter's value sits at its own read address. Software enables the counters it needs, lets them run, and reads the values back.

Counter 0 is the timebase and the master of the unit. It counts clock cycles and nothing else. When it is disabled or has overflowed, every counter is frozen. Its overflow also raises the interrupt. The other counters wrap silently when they overflow, record the event in their own flag and keep counting. The clear bit works differently on the two kinds of counter. Counter 0 clears on a written 0-to-1 transition of its clear bit. An event counter clears when its clear bit is written as 0, and that bit then reads back as 1.

Top module: `mcpc_top`

## Requirements
- R1: Control word n is at byte address 4*n and the value of counter n is at 0x20 + 4*n. A read returns its data on `reg_rdata` in the cycle after `reg_rd`, and `reg_rdata` holds between reads. Any other address reads as 0, and a write to it changes nothing.
- R2: In a control word, bit 0 is the overflow flag, bit 1 is the clear bit, bit 2 is the enable and bits 31:24 are the event-select code. All other bits read as 0. After reset, every field is 0 except the clear bit of counters 1 to 3, which reads 1.
- R3: Counter 0 adds one on every clock edge while it is enabled and its overflow flag is low. Its select field always reads 0, whatever is written to it.
- R4: Counters 1 to 3 count only while counter 0 is running. While enabled, a counter adds one per edge according to its code: code 0x00 counts every cycle, codes 1 to NUM_EVT-1 count the edges where `ev_strobe[code]` is high, and any larger code counts nothing.
- R5: When counter 0 increments past its maximum, it becomes 0 and sets its overflow flag. All counters then hold their values until that flag is cleared.
- R6: `irq` is a registered output. It goes high one cycle after counter 0's overflow flag and enable are both set, and it goes low one cycle after either of them drops.
- R7: When counter 1, 2 or 3 increments past its maximum, it wraps to 0, sets its own overflow flag and keeps counting. The interrupt is not raised.
- R8: While counter 0 is disabled, all counts hold. Re-enabling counter 0 without a clear resumes counting from the held values.
- R9: Counter 0 clears only on a write that sets its clear bit while the stored clear bit is 0. Writing 1 over a stored 1 leaves the count unchanged. Writing all zeros disables counter 0 and keeps its count.
- R10: A write to counter 1, 2 or 3 with the clear bit at 0 resets that count to 0, and the clear bit still reads back as 1.
- R11: An overflow flag is sticky. A control write with bit 0 low clears it. A write with bit 0 high leaves it unchanged, and software can never set it.
- R12: If a clear and an increment fall in the same cycle, the counter ends at 0. An increment in the cycle of a control write uses the enable that was in force before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_strobe | input | NUM_EVT | Event strobes from the controller, one bit per event code |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Interrupt on cycle-counter overflow |

## Verification
The bench builds the unit with 8-bit counters and 16 event strobes. With these values, counter 0 overflows after 256 cycles, so the global freeze, the interrupt and the wrap of an event counter can all be reached within a few hundred cycles. With 16 strobes, the codes 16 to 255 cover the "counts nothing" case. The bench sweeps all 256 select codes across the three event counters under a pseudo-random strobe pattern, and compares every read against a cycle-level model built from the requirements.

// File: rtl/mcpc_pkg.sv
package mcpc_pkg;

  localparam int DATA_W  = 32;
  localparam int SEL_W   = 8;
  localparam int OVF_BIT = 0;
  localparam int CLR_BIT = 1;
  localparam int EN_BIT  = 2;
  localparam int SEL_LSB = 24;

  // Named event-select codes for the controller strobes
  localparam logic [SEL_W-1:0] EVC_CYCLE    = 8'h00;
  localparam logic [SEL_W-1:0] EVC_SELF_REF = 8'h01;
  localparam logic [SEL_W-1:0] EVC_RD_ACC   = 8'h04;
  localparam logic [SEL_W-1:0] EVC_WR_ACC   = 8'h05;
  localparam logic [SEL_W-1:0] EVC_RD_CMD   = 8'h20;
  localparam logic [SEL_W-1:0] EVC_WR_CMD   = 8'h21;
  localparam logic [SEL_W-1:0] EVC_PRECHG   = 8'h31;
  localparam logic [SEL_W-1:0] EVC_ACTIVATE = 8'h32;
  localparam logic [SEL_W-1:0] EVC_REFRESH  = 8'h37;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             en;
    logic             clr;
    logic             ovf;
  } ctl_t;

  function automatic logic [DATA_W-1:0] ctl_word(ctl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[SEL_LSB +: SEL_W] = c.sel;
    w[EN_BIT]           = c.en;
    w[CLR_BIT]          = c.clr;
    w[OVF_BIT]          = c.ovf;
    return w;
  endfunction

endpackage

// File: rtl/mcpc_evt_sel.sv
module mcpc_evt_sel
  import mcpc_pkg::*;
#(
  parameter int NUM_EVT = 64
) (
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_EVT-1:0] ev,
  output logic               hit
);
  localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic [IDX_W-1:0] idx;
  logic             in_range;

  assign idx      = sel[IDX_W-1:0];
  assign in_range = (int'(sel) < NUM_EVT);

  always_comb begin
    if (sel == EVC_CYCLE) hit = 1'b1;
    else if (in_range)    hit = ev[idx];
    else                  hit = 1'b0;
  end
endmodule

// File: rtl/mcpc_ctr.sv
module mcpc_ctr
  import mcpc_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter bit IS_CYCLE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  ctl_t             wr_ctl,
  input  logic             run,
  input  logic             hit,
  output logic [CNT_W-1:0] cnt_o,
  output ctl_t             ctl_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             en_q;
  logic             ovf_q;
  logic [SEL_W-1:0] sel_q;
  logic             clr_now;
  logic             clr_bit;
  logic             inc;
  logic             wrap;

  generate
    if (IS_CYCLE) begin : g_cyc
      logic             clr_q;
      logic [SEL_W-1:0] sel_unused;
      assign sel_unused = wr_ctl.sel;
      always_ff @(posedge clk) begin
        if (rst)         clr_q <= 1'b0;
        else if (wr_hit) clr_q <= wr_ctl.clr;
      end
      assign clr_now = wr_hit & wr_ctl.clr & ~clr_q;
      assign clr_bit = clr_q;
    end else begin : g_evt
      assign clr_now = wr_hit & ~wr_ctl.clr;
      assign clr_bit = 1'b1;
    end
  endgenerate

  assign inc  = en_q & run & hit;
  assign wrap = inc & (&cnt_q) & ~clr_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clr_now) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else if (wr_hit) begin
      en_q  <= wr_ctl.en;
      sel_q <= IS_CYCLE ? '0 : wr_ctl.sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                         ovf_q <= 1'b0;
    else if (wrap)                   ovf_q <= 1'b1;
    else if (wr_hit && !wr_ctl.ovf)  ovf_q <= 1'b0;
  end

  assign cnt_o     = cnt_q;
  assign ctl_o.sel = sel_q;
  assign ctl_o.en  = en_q;
  assign ctl_o.clr = clr_bit;
  assign ctl_o.ovf = ovf_q;

  // R7 / R5: an increment past the top wraps to zero and raises the flag
  a_r7_wrap_sets_ovf: assert property (@(posedge clk) disable iff (rst)
    (inc && (&cnt_q) && !clr_now) |=> (cnt_q == '0 && ovf_q));

  // R12: a clear wins over a same-cycle increment
  a_r12_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr_now |=> (cnt_q == '0));

  // R8: with neither increment nor clear the value holds
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!inc && !clr_now) |=> $stable(cnt_q));
endmodule

// File: rtl/mcpc_regif.sv
module mcpc_regif
  import mcpc_pkg::*;
#(
  parameter int NUM_CTR  = 4,
  parameter int CNT_W    = 32,
  parameter int ADDR_W   = 8,
  parameter int CNT_BASE = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reg_wr,
  input  logic                          reg_rd,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [DATA_W-1:0]             reg_wdata,
  input  ctl_t [NUM_CTR-1:0]            ctl_in,
  input  logic [NUM_CTR-1:0][CNT_W-1:0] cnt_in,
  output logic [NUM_CTR-1:0]            wr_hit,
  output ctl_t                          wr_ctl,
  output logic [DATA_W-1:0]             reg_rdata
);
  logic [DATA_W-1:0] rd_mux;
  logic              rd_valid;
  logic [20:0]       wdata_unused;

  assign wdata_unused = reg_wdata[SEL_LSB-1:EN_BIT+1];
  assign wr_ctl.sel   = reg_wdata[SEL_LSB +: SEL_W];
  assign wr_ctl.en    = reg_wdata[EN_BIT];
  assign wr_ctl.clr   = reg_wdata[CLR_BIT];
  assign wr_ctl.ovf   = reg_wdata[OVF_BIT];

  generate
    for (genvar n = 0; n < NUM_CTR; n++) begin : g_dec
      assign wr_hit[n] = reg_wr && (reg_addr == ADDR_W'(4 * n));
    end
  endgenerate

  always_comb begin
    rd_mux   = '0;
    rd_valid = 1'b0;
    for (int n = 0; n < NUM_CTR; n++) begin
      if (reg_addr == ADDR_W'(4 * n)) begin
        rd_mux   = ctl_word(ctl_in[n]);
        rd_valid = 1'b1;
      end
      if (reg_addr == ADDR_W'(CNT_BASE + 4 * n)) begin
        rd_mux   = DATA_W'(cnt_in[n]);
        rd_valid = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  // R1: unmapped addresses read as zero
  a_r1_bad_addr_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !rd_valid) |=> (reg_rdata == '0));

  // R1: read data holds between reads
  a_r1_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: rtl/mcpc_top.sv
module mcpc_top
  import mcpc_pkg::*;
#(
  parameter int NUM_CTR  = 4,
  parameter int CNT_W    = 32,
  parameter int NUM_EVT  = 64,
  parameter int ADDR_W   = 8,
  parameter int CNT_BASE = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] ev_strobe,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq
);
  ctl_t [NUM_CTR-1:0]            ctl_all;
  logic [NUM_CTR-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_CTR-1:0]            wr_hit;
  logic [NUM_CTR-1:0]            hit;
  ctl_t                          wr_ctl;
  logic                          run_all;

  // Counter 0 is the timebase: it gates every counter in the unit
  assign run_all = ctl_all[0].en & ~ctl_all[0].ovf;

  mcpc_regif #(
    .NUM_CTR (NUM_CTR),
    .CNT_W   (CNT_W),
    .ADDR_W  (ADDR_W),
    .CNT_BASE(CNT_BASE)
  ) u_regif (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .ctl_in   (ctl_all),
    .cnt_in   (cnt_all),
    .wr_hit   (wr_hit),
    .wr_ctl   (wr_ctl),
    .reg_rdata(reg_rdata)
  );

  generate
    for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
      if (n == 0) begin : g_time
        assign hit[n] = 1'b1;
      end else begin : g_sel
        mcpc_evt_sel #(.NUM_EVT(NUM_EVT)) u_sel (
          .sel(ctl_all[n].sel),
          .ev (ev_strobe),
          .hit(hit[n])
        );
      end
      mcpc_ctr #(
        .CNT_W   (CNT_W),
        .IS_CYCLE(n == 0)
      ) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .wr_hit(wr_hit[n]),
        .wr_ctl(wr_ctl),
        .run   (run_all),
        .hit   (hit[n]),
        .cnt_o (cnt_all[n]),
        .ctl_o (ctl_all[n])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= ctl_all[0].ovf & ctl_all[0].en;
  end

  // R5: after a timebase overflow, no count moves unless software writes
  a_r5_freeze_all: assert property (@(posedge clk) disable iff (rst)
    (ctl_all[0].ovf && !reg_wr) |=> $stable(cnt_all));

  // R6: interrupt follows the timebase flag and enable
  a_r6_irq_rise: assert property (@(posedge clk) disable iff (rst)
    (ctl_all[0].ovf && ctl_all[0].en) |=> irq);

  a_r6_irq_fall: assert property (@(posedge clk) disable iff (rst)
    !(ctl_all[0].ovf && ctl_all[0].en) |=> !irq);
endmodule

// File: tb/mcpc_top_bench.sv
module mcpc_top_bench;
  localparam int NC   = 4;
  localparam int CW   = 8;
  localparam int NE   = 16;
  localparam int AW   = 8;
  localparam int MAXV = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NE-1:0] ev = '0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [15:0] lf = 16'hACE1;

  always #2 clk = ~clk;

  mcpc_top #(.NUM_CTR(NC), .CNT_W(CW), .NUM_EVT(NE), .ADDR_W(AW)) u_mcpc_top (
    .clk(clk), .rst(rst), .ev_strobe(ev), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // Cycle-level expectation derived from the requirements
  int unsigned m_cnt [NC];
  bit          m_en  [NC];
  bit [7:0]    m_sel [NC];
  bit          m_ovf [NC];
  bit          m_clr0;
  bit          m_irq;
  logic [31:0] m_rd;

  function automatic logic [31:0] m_word(logic [AW-1:0] a);
    logic [31:0] w;
    w = '0;
    for (int n = 0; n < NC; n++) begin
      if (a == AW'(4 * n))
        w = {m_sel[n], 21'b0, m_en[n], (n == 0) ? m_clr0 : 1'b1, m_ovf[n]};
      if (a == AW'(32 + 4 * n)) w = 32'(m_cnt[n]);
    end
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < NC; n++) begin
        m_cnt[n] = 0; m_en[n] = 0; m_sel[n] = 0; m_ovf[n] = 0;
      end
      m_clr0 = 0; m_irq = 0; m_rd = '0;
    end else begin
      bit run, h, inc, wn, cn, nirq;
      if (reg_rd) m_rd = m_word(reg_addr);
      nirq = m_en[0] & m_ovf[0];
      run  = m_en[0] && !m_ovf[0];
      for (int n = 0; n < NC; n++) begin
        if (n == 0 || m_sel[n] == 0) h = 1;
        else if (m_sel[n] < NE)      h = ev[m_sel[n]];
        else                         h = 0;
        inc = m_en[n] && run && h;
        wn  = reg_wr && reg_addr == AW'(4 * n);
        cn  = (n == 0) ? (wn && reg_wdata[1] && !m_clr0) : (wn && !reg_wdata[1]);
        if (cn) m_cnt[n] = 0;
        else if (inc) begin
          if (m_cnt[n] == MAXV) begin m_cnt[n] = 0; m_ovf[n] = 1; end
          else m_cnt[n] = m_cnt[n] + 1;
        end
        if (wn && !reg_wdata[0] && !(inc && !cn && m_cnt[n] == 0)) m_ovf[n] = 0;
        if (wn) begin
          m_en[n]  = reg_wdata[2];
          m_sel[n] = (n == 0) ? 8'h00 : reg_wdata[31:24];
          if (n == 0) m_clr0 = reg_wdata[1];
        end
      end
      m_irq = nirq;
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    ev = '0; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, string tag);
    @(negedge clk);
    ev = '0; reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(tag, reg_rdata, m_rd);
  endtask

  task automatic rd_exp(logic [AW-1:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    ev = '0; reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      ev = lf[NE-1:0];
    end
    @(negedge clk);
    ev = '0;
  endtask

  task automatic chk_irq(string tag, bit exp);
    @(negedge clk);
    chk(tag, 32'(irq), 32'(exp));
    chk(tag, 32'(irq), 32'(m_irq));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // Reset state (R2, R10) and address map (R1)
    rd_exp(8'h00, 32'h0, "R2 reset ctl0");
    for (int n = 1; n < NC; n++) rd_exp(AW'(4 * n), 32'h2, "R10 reset ctl clr reads 1");
    for (int n = 0; n < NC; n++) rd_exp(AW'(32 + 4 * n), 32'h0, "R1 reset count");
    rd_exp(8'h40, 32'h0, "R1 unmapped read");
    rd_exp(8'h02, 32'h0, "R1 misaligned read");
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h00, "R1 unmapped write ignored");
    chk_irq("R6 idle irq low", 1'b0);

    // Sweep all select codes over the event counters (R4, R3, R2)
    for (int c = 0; c < 256; c++) begin
      wr(8'h00, 32'h0);
      wr(8'h00, 32'h6);
      for (int n = 1; n < NC; n++) begin
        logic [7:0] code;
        code = (n == 1) ? 8'(c) : (n == 2) ? 8'(c ^ 8'h55) : 8'(c + 3);
        wr(AW'(4 * n), 32'h0);
        wr(AW'(4 * n), {code, 24'h000006});
      end
      idle(24);
      wr(8'h00, 32'h0);
      rd(8'h20, "R3 cycle count");
      for (int n = 1; n < NC; n++) begin
        rd(AW'(32 + 4 * n), "R4 event count");
        rd(AW'(4 * n), "R2 ctl readback");
      end
    end

    // R3: select field of counter 0 ignores writes
    wr(8'h00, 32'hFF00_0006);
    rd_exp(8'h00, 32'h0000_0006, "R3 ctl0 sel reads 0");

    // R8: disable holds, re-enable without clear resumes
    wr(8'h04, 32'h0);
    wr(8'h04, 32'h6);
    idle(10);
    wr(8'h00, 32'h0);
    rd(8'h24, "R8 held count");
    idle(5);
    rd(8'h24, "R8 still held");
    rd(8'h20, "R9 zero write keeps count");
    wr(8'h00, 32'h4);
    idle(7);
    rd(8'h24, "R8 resumed count");
    // R9: 0->1 of clear bit clears; 1 over 1 does not
    wr(8'h00, 32'h6);
    rd(8'h20, "R9 rising clear");
    idle(5);
    wr(8'h00, 32'h6);
    rd(8'h20, "R9 no clear on 1 over 1");

    // R7: event counter wraps silently while timebase is refreshed
    wr(8'h00, 32'h0);
    wr(8'h00, 32'h6);
    wr(8'h04, 32'h0);
    wr(8'h04, 32'h6);
    for (int k = 0; k < 3; k++) begin
      idle(120);
      wr(8'h00, 32'h4);
      wr(8'h00, 32'h6);
    end
    rd(8'h04, "R7 event ovf flag");
    rd(8'h24, "R7 event wrapped count");
    chk_irq("R7 no irq on event wrap", 1'b0);
    // R11: sticky flag; bit0 high keeps it, low clears it
    wr(8'h04, 32'h7);
    rd(8'h04, "R11 flag kept");
    wr(8'h04, 32'h6);
    rd(8'h04, "R11 flag cleared");

    // R12: clear in the same cycle as an active event
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h0; ev = '1;
    @(negedge clk);
    reg_wr = 1'b0; ev = '0;
    rd_exp(8'h24, 32'h0, "R12 clear wins");

    // R5/R6: timebase overflow freezes everything and interrupts
    wr(8'h04, 32'h6);
    wr(8'h00, 32'h0);
    wr(8'h00, 32'h6);
    idle(300);
    rd(8'h00, "R5 timebase flag set");
    rd(8'h20, "R5 timebase wrapped");
    rd(8'h24, "R5 frozen count");
    idle(20);
    rd(8'h24, "R5 still frozen");
    chk_irq("R6 irq raised", 1'b1);
    wr(8'h00, 32'h1);
    chk_irq("R6 irq drops on disable", 1'b0);
    rd(8'h00, "R11 timebase flag kept");
    wr(8'h00, 32'h4);
    idle(5);
    rd(8'h00, "R11 timebase flag cleared");
    rd(8'h20, "R8 timebase resumed");
    chk_irq("R6 irq stays low", 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule